// File: doc/BRIEF.md
# Fault-Injecting Decision Diagram Walker

This block evaluates one output word by walking a decision diagram held in a node table. The table is presented as a single flat input vector. Node 0 is the root. An internal node reads one of the control variables and uses that variable's value to pick one of four successor pointers. A terminal node ends the walk and produces a word. That word is zero, one of the three data inputs passed through, or a sum or product of two of them. A one-cycle start request launches a walk. A one-cycle done pulse ends it, and the index of the terminal node that was reached is reported with the result.

A fault port can change how one chosen internal node selects its successor, and this turns the walker into a fault simulator. Three fault kinds are supported:

- **Stuck:** the node always follows the edge of one given value.
- **Broken:** the edge of one given value leads nowhere, so the walk aborts and the previous output is held.
- **Redirect:** when the variable takes one given value, the node follows the edge of another value instead.

A bound on the number of internal nodes visited stops a walk that cycles.

Top module: `dd_fault_eval`

## Requirements
- R1: During and right after reset, busy, done and err are 0, and result and term_idx are 0.
- R2: A start sampled while idle begins a walk at node 0, and the walk visits one node per clock. With L internal nodes on the path, done rises for exactly one cycle at the (L+1)-th rising edge after the edge that sampled start.
- R3: Node n occupies bits [22n+21:22n] of the table. Successor v sits in bits [4v+3:4v], the opcode in [18:16], the variable index in [20:19], and the terminal flag in bit 21. Control variable k is ctrl_vals[2k+1:2k]. An internal node whose variable has value v moves to successor v.
- R4: A terminal produces a result that depends on its opcode: 0 gives zero, 1 gives data_a, 2 gives data_b, 3 gives data_in, 4 gives data_a+data_b, 5 gives data_in+data_b, 6 gives data_a*data_b, and 7 gives data_in*data_b. Sums and products are taken modulo 2^WIDTH. term_idx takes the terminal's index. result changes only in a cycle in which done is high.
- R5: With fault kind 0 (none), result and term_idx match a combinational walk of the table for every one of the 256 control patterns.
- R6: Fault kind 1 (stuck) at node flt_node makes that node follow successor flt_from, whatever the value of its variable.
- R7: Fault kind 2 (broken) at flt_node makes the walk end with done and err high, and result and term_idx unchanged, when the node's variable equals flt_from. Other values of the variable walk normally.
- R8: Fault kind 3 (redirect) at flt_node makes that node follow successor flt_to when its variable equals flt_from, and the normal successor for any other value.
- R9: A fault aimed at a node that the walk does not pass through as an internal node, including a terminal node, leaves the outcome unchanged.
- R10: When 16 internal nodes are visited without reaching a terminal, the walk ends at the 16th edge with done and err high, and result and term_idx unchanged.
- R11: A start asserted while a walk is in progress is ignored and produces no extra done.
- R12: In the sample diagram, the pattern y4=2, y3=3, y2=0 reaches the terminal that computes data_a*data_b. Here y4, y3 and y2 are variables 3, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a walk |
| node_tbl | input | NODES*22 | Flat node table |
| ctrl_vals | input | NVARS*VAL_W | Control variable values |
| data_a | input | WIDTH | First register operand |
| data_b | input | WIDTH | Second register operand |
| data_in | input | WIDTH | Input bus operand |
| flt_kind | input | 2 | Fault kind: 0 none, 1 stuck, 2 broken, 3 redirect |
| flt_node | input | 4 | Index of the faulted node |
| flt_from | input | VAL_W | Value whose edge is affected |
| flt_to | input | VAL_W | Replacement edge for redirect |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk ended without reaching a terminal |
| result | output | WIDTH | Last terminal value |
| term_idx | output | 4 | Index of the last terminal reached |

## Verification
The bench uses the default parameters: an 8-bit word, 16 nodes, and four control variables of 2 bits each. With these values the full 256-pattern control space can be swept against the golden walk. The 8-bit word lets a product such as 20*13 wrap. Two nodes pointing at each other reach the 16-step limit within a short run, and a four-level sample diagram gives paths of distinct lengths, which allows the latency to be checked.

// File: rtl/dd_pkg.sv
package dd_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      TOP_ZERO   = 3'd0,
      TOP_PASS_A = 3'd1,
      TOP_PASS_B = 3'd2,
      TOP_PASS_I = 3'd3,
      TOP_ADD_AB = 3'd4,
      TOP_ADD_IB = 3'd5,
      TOP_MUL_AB = 3'd6,
      TOP_MUL_IB = 3'd7
   } term_op_e;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_STUCK  = 2'd1,
      FK_BROKEN = 2'd2,
      FK_REDIR  = 2'd3
   } flt_kind_e;

   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_WALK = 1'b1
   } walk_state_e;
endpackage

// File: rtl/dd_succ_sel.sv
module dd_succ_sel
   import dd_pkg::*;
#(
   parameter int PTR_W = 4,
   parameter int VAL_W = 2,
   localparam int ARITY = 1 << VAL_W
) (
   input  logic [ARITY*PTR_W-1:0] succ_flat,
   input  logic [VAL_W-1:0]       var_val,
   input  logic [PTR_W-1:0]       cur_ptr,
   input  flt_kind_e              flt_kind,
   input  logic [PTR_W-1:0]       flt_node,
   input  logic [VAL_W-1:0]       flt_from,
   input  logic [VAL_W-1:0]       flt_to,
   output logic [PTR_W-1:0]       next_ptr,
   output logic                   edge_broken
);
   logic [PTR_W-1:0] succ_arr [ARITY];
   logic [VAL_W-1:0] eff_val;
   logic             hit;

   for (genvar v = 0; v < ARITY; v++) begin : g_unpack
      assign succ_arr[v] = succ_flat[v*PTR_W +: PTR_W];
   end

   assign hit = (flt_node == cur_ptr);

   always_comb begin
      eff_val     = var_val;
      edge_broken = 1'b0;
      if (hit) begin
         case (flt_kind)
            FK_STUCK:  eff_val = flt_from;
            FK_BROKEN: edge_broken = (var_val == flt_from);
            FK_REDIR:  if (var_val == flt_from) eff_val = flt_to;
            default:   eff_val = var_val;
         endcase
      end
   end

   assign next_ptr = succ_arr[eff_val];
endmodule

// File: rtl/dd_term_alu.sv
module dd_term_alu
   import dd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  term_op_e         op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [WIDTH-1:0] opi,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      case (op)
         TOP_ZERO:   y = '0;
         TOP_PASS_A: y = opa;
         TOP_PASS_B: y = opb;
         TOP_PASS_I: y = opi;
         TOP_ADD_AB: y = opa + opb;
         TOP_ADD_IB: y = opi + opb;
         TOP_MUL_AB: y = opa * opb;
         TOP_MUL_IB: y = opi * opb;
         default:    y = '0;
      endcase
   end
endmodule

// File: rtl/dd_fault_eval.sv
module dd_fault_eval
   import dd_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int NODES     = 16,
   parameter int NVARS     = 4,
   parameter int VAL_W     = 2,
   parameter int MAX_STEPS = 16,
   localparam int PTR_W    = $clog2(NODES),
   localparam int ARITY    = 1 << VAL_W,
   localparam int VSEL_W   = $clog2(NVARS),
   localparam int OP_LO    = ARITY * PTR_W,
   localparam int VAR_LO   = OP_LO + OP_W,
   localparam int TERM_BIT = VAR_LO + VSEL_W,
   localparam int NODE_W   = TERM_BIT + 1,
   localparam int CNT_W    = $clog2(MAX_STEPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [NODES*NODE_W-1:0] node_tbl,
   input  logic [NVARS*VAL_W-1:0]  ctrl_vals,
   input  logic [WIDTH-1:0]        data_a,
   input  logic [WIDTH-1:0]        data_b,
   input  logic [WIDTH-1:0]        data_in,
   input  logic [1:0]              flt_kind,
   input  logic [PTR_W-1:0]        flt_node,
   input  logic [VAL_W-1:0]        flt_from,
   input  logic [VAL_W-1:0]        flt_to,
   output logic                    busy,
   output logic                    done,
   output logic                    err,
   output logic [WIDTH-1:0]        result,
   output logic [PTR_W-1:0]        term_idx
);
   if (NODES < 2 || (1 << PTR_W) != NODES) begin : g_bad_nodes
      $error("NODES must be a power of two of at least 2");
   end
   if (NVARS < 2 || (1 << VSEL_W) != NVARS) begin : g_bad_vars
      $error("NVARS must be a power of two of at least 2");
   end
   if (MAX_STEPS < 2 || (1 << CNT_W) != MAX_STEPS) begin : g_bad_steps
      $error("MAX_STEPS must be a power of two of at least 2");
   end
   if (VAL_W < 1 || WIDTH < 1) begin : g_bad_width
      $error("VAL_W and WIDTH must be positive");
   end

   walk_state_e             state;
   logic [PTR_W-1:0]        cur_ptr;
   logic [CNT_W-1:0]        step_cnt;
   logic [NODE_W-1:0]       cur_word;
   logic                    cur_is_term;
   logic [VSEL_W-1:0]       cur_var;
   term_op_e                cur_op;
   logic [ARITY*PTR_W-1:0]  cur_succ;
   logic [VAL_W-1:0]        cur_val;
   logic [VAL_W-1:0]        var_arr [NVARS];
   logic [PTR_W-1:0]        next_ptr;
   logic                    edge_broken;
   logic [WIDTH-1:0]        alu_y;
   logic                    step_last;

   for (genvar k = 0; k < NVARS; k++) begin : g_vars
      assign var_arr[k] = ctrl_vals[k*VAL_W +: VAL_W];
   end

   assign cur_word    = node_tbl[cur_ptr*NODE_W +: NODE_W];
   assign cur_is_term = cur_word[TERM_BIT];
   assign cur_var     = cur_word[VAR_LO +: VSEL_W];
   assign cur_op      = term_op_e'(cur_word[OP_LO +: OP_W]);
   assign cur_succ    = cur_word[ARITY*PTR_W-1:0];
   assign cur_val     = var_arr[cur_var];
   assign step_last   = (step_cnt == CNT_W'(MAX_STEPS - 1));

   dd_succ_sel #(.PTR_W(PTR_W), .VAL_W(VAL_W)) succ_i (
      .succ_flat   (cur_succ),
      .var_val     (cur_val),
      .cur_ptr     (cur_ptr),
      .flt_kind    (flt_kind_e'(flt_kind)),
      .flt_node    (flt_node),
      .flt_from    (flt_from),
      .flt_to      (flt_to),
      .next_ptr    (next_ptr),
      .edge_broken (edge_broken)
   );

   dd_term_alu #(.WIDTH(WIDTH)) alu_i (
      .op  (cur_op),
      .opa (data_a),
      .opb (data_b),
      .opi (data_in),
      .y   (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WS_IDLE;
         cur_ptr  <= '0;
         step_cnt <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         result   <= '0;
         term_idx <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            WS_IDLE: begin
               if (start) begin
                  state    <= WS_WALK;
                  cur_ptr  <= '0;
                  step_cnt <= '0;
               end
            end
            default: begin
               if (cur_is_term) begin
                  result   <= alu_y;
                  term_idx <= cur_ptr;
                  done     <= 1'b1;
                  state    <= WS_IDLE;
               end else if (edge_broken || step_last) begin
                  done  <= 1'b1;
                  err   <= 1'b1;
                  state <= WS_IDLE;
               end else begin
                  cur_ptr  <= next_ptr;
                  step_cnt <= step_cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (state == WS_WALK);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   // R7
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   // R10
   hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(result) && $stable(term_idx)));
   // R4
   result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

// File: tb/dd_fault_eval_tb.sv
module dd_fault_eval_tb_top;
   localparam int NW = 22;

   typedef struct {
      logic [7:0] res;
      logic [3:0] term;
      logic       err;
      string      req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [16*NW-1:0] tbl = '0;
   logic [7:0]    ctrl = '0;
   logic [7:0]    da = 8'd20, db = 8'd13, di = 8'd7;
   logic [1:0]    fk = 2'd0;
   logic [3:0]    fn = '0;
   logic [1:0]    ff = '0, ft = '0;
   logic          busy, done, err;
   logic [7:0]    result;
   logic [3:0]    term_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   exp_t q[$];
   logic [7:0] m_res = '0;
   logic [3:0] m_term = '0;

   always #5 clk = ~clk;

   dd_fault_eval dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .node_tbl(tbl), .ctrl_vals(ctrl),
      .data_a(da), .data_b(db), .data_in(di), .flt_kind(fk), .flt_node(fn),
      .flt_from(ff), .flt_to(ft), .busy(busy), .done(done), .err(err),
      .result(result), .term_idx(term_idx)
   );

   function automatic logic [NW-1:0] mk_int(input int v, input int s0, input int s1,
                                             input int s2, input int s3);
      logic [NW-1:0] w = '0;
      w[20:19] = 2'(v);
      w[3:0] = 4'(s0); w[7:4] = 4'(s1); w[11:8] = 4'(s2); w[15:12] = 4'(s3);
      return w;
   endfunction

   function automatic logic [NW-1:0] mk_term(input int op);
      logic [NW-1:0] w = '0;
      w[21] = 1'b1;
      w[18:16] = 3'(op);
      return w;
   endfunction

   function automatic logic [7:0] ref_op(input logic [2:0] op);
      case (op)
         3'd0: return 8'd0;
         3'd1: return da;
         3'd2: return db;
         3'd3: return di;
         3'd4: return 8'(da + db);
         3'd5: return 8'(di + db);
         3'd6: return 8'(da * db);
         default: return 8'(di * db);
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic gold(input logic [7:0] c, output exp_t e, output int cyc);
      logic [3:0] ptr = '0;
      logic [NW-1:0] w;
      logic [1:0] v, sel;
      bit fin = 1'b0;
      e.res = m_res; e.term = m_term; e.err = 1'b0; cyc = 0;
      for (int s = 0; s < 17 && !fin; s++) begin
         cyc = s + 1;
         w = tbl[ptr*NW +: NW];
         if (w[21]) begin
            e.res = ref_op(w[18:16]); e.term = ptr; fin = 1'b1;
         end else begin
            v = c[w[20:19]*2 +: 2];
            if ((fk == 2'd2 && fn == ptr && v == ff) || s == 15) begin
               e.err = 1'b1; fin = 1'b1;
            end else begin
               sel = v;
               if (fk == 2'd1 && fn == ptr) sel = ff;
               if (fk == 2'd3 && fn == ptr && v == ff) sel = ft;
               ptr = w[sel*4 +: 4];
            end
         end
      end
      if (!e.err) begin m_res = e.res; m_term = e.term; end
   endtask

   task automatic run_case(input logic [7:0] c, input string req, input int hold);
      exp_t e;
      int cyc, cnt;
      gold(c, e, cyc);
      e.req = req;
      q.push_back(e);
      @(negedge clk);
      ctrl = c;
      start = 1'b1;
      @(posedge clk);
      cnt = 0;
      do begin
         @(negedge clk);
         if (cnt >= hold - 1) start = 1'b0;
         @(posedge clk);
         #1;
         cnt++;
      end while (!done && cnt < 100);
      // R2 latency
      check(cnt == cyc, {req, " R2 latency"}, cnt, cyc);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops expected items as done pulses appear
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && done) begin
            if (q.size() == 0) begin
               check(1'b0, "R11 unexpected done", 1, 0);
            end else begin
               e = q.pop_front();
               check(result == e.res, {e.req, " result"}, result, e.res);
               check(term_idx == e.term, {e.req, " term_idx"}, term_idx, e.term);
               check(err == e.err, {e.req, " err"}, err, e.err);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // sample diagram: variable 3 = y4, 2 = y3, 1 = y2
      tbl[0*NW +: NW]  = mk_int(3, 1, 2, 3, 4);
      tbl[1*NW +: NW]  = mk_term(0);
      tbl[2*NW +: NW]  = mk_term(1);
      tbl[3*NW +: NW]  = mk_int(2, 5, 6, 2, 7);
      tbl[4*NW +: NW]  = mk_int(0, 8, 9, 10, 1);
      tbl[5*NW +: NW]  = mk_term(2);
      tbl[6*NW +: NW]  = mk_term(3);
      tbl[7*NW +: NW]  = mk_int(1, 11, 12, 13, 14);
      tbl[8*NW +: NW]  = mk_term(4);
      tbl[9*NW +: NW]  = mk_term(5);
      tbl[10*NW +: NW] = mk_term(7);
      tbl[11*NW +: NW] = mk_term(6);
      tbl[12*NW +: NW] = mk_term(4);
      tbl[13*NW +: NW] = mk_term(1);
      tbl[14*NW +: NW] = mk_int(0, 15, 15, 5, 6);
      tbl[15*NW +: NW] = mk_term(7);

      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
      check(result == 8'd0 && term_idx == 4'd0, "R1 outputs", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && result == 8'd0, "R1 after release", result, 0);

      // R12 sample pattern y4=2 y3=3 y2=0 -> data_a*data_b = 260 mod 256
      run_case(8'b10_11_00_00, "R12", 1);
      check(result == 8'd4 && term_idx == 4'd11, "R12 product", result, 4);
      // R3 one-level path, R4 zero terminal
      run_case(8'b01_00_00_00, "R3", 1);
      run_case(8'b00_00_00_00, "R4", 1);
      // R5 full sweep, fault off
      for (int p = 0; p < 256; p++) run_case(8'(p), "R5", 1);

      // R6 stuck: node 3 always takes edge 0 -> node 5 (data_b)
      fk = 2'd1; fn = 4'd3; ff = 2'd0;
      run_case(8'b10_11_00_00, "R6", 1);
      check(result == db && term_idx == 4'd5, "R6 stuck edge", result, db);
      run_case(8'b10_01_00_00, "R6", 1);

      // R7 broken: node 7 value 0
      fk = 2'd2; fn = 4'd7; ff = 2'd0;
      run_case(8'b10_11_00_00, "R7", 1);
      check(result == db && term_idx == 4'd5, "R7 held output", result, db);
      run_case(8'b10_11_01_00, "R7", 1);

      // R8 redirect: node 0 value 1 goes to edge 3 (node 4)
      fk = 2'd3; fn = 4'd0; ff = 2'd1; ft = 2'd3;
      run_case(8'b01_00_00_10, "R8", 1);
      check(result == 8'(di * db) && term_idx == 4'd10, "R8 redirect", result, 8'(di * db));
      run_case(8'b10_00_00_00, "R8", 1);

      // R9 fault on a node off the path, and on a terminal
      fk = 2'd1; fn = 4'd4; ff = 2'd3;
      run_case(8'b10_11_00_00, "R9", 1);
      fn = 4'd11;
      run_case(8'b10_11_00_00, "R9", 1);
      check(term_idx == 4'd11, "R9 terminal fault", term_idx, 11);
      fk = 2'd0;

      // R11 start held during a walk
      run_case(8'b10_11_01_00, "R11", 3);

      // R10 two nodes pointing at each other
      tbl[0*NW +: NW] = mk_int(0, 1, 1, 1, 1);
      tbl[1*NW +: NW] = mk_int(1, 0, 0, 0, 0);
      run_case(8'h00, "R10", 1);
      check(term_idx == 4'd12, "R10 held term", term_idx, 12);

      repeat (5) @(negedge clk);
      check(q.size() == 0, "R11 pending items", q.size(), 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule